// File: doc/BRIEF.md
# Special-Register Programmable Interrupt Controller

This block collects 32 interrupt request lines beside a processor core and turns them into one interrupt request for the core's external-interrupt exception. Software reaches it through special-purpose register accesses. Two 32-bit registers are visible, one select bit chooses between them, writes take effect on the clock edge, and reads are combinational. The enable register holds one bit per line. The pending register holds one bit per line. The core interrupt is raised whenever any line is both pending and enabled.

A build-time parameter fixes how the pending register behaves. In level mode each pending bit follows its synchronised input, and software does not acknowledge it. In edge mode a rising edge sets the pending bit, and software clears it by writing a one to it. In legacy sticky mode an asserted input is captured into a sticky bit, and software clears it by writing a zero to it. For a legacy acknowledge, software reads the register, clears the one bit it wants and writes the value back. In both latching modes, a set that arrives in the same cycle as a clear wins.

A convenience output gives the lowest-numbered line that is both pending and enabled. Software can start its scan there and then move to higher lines.

Top module: `spr_pic`

## Requirements
- R1: After reset the enable register and the pending register both read 0x00000000, and cpuIrq and pendValid are 0.
- R2: A write with regSel=0 replaces the whole enable register with regWdata. A bit value of 1 enables that line.
- R3: cpuIrq is 1 exactly when some bit is set in both the pending register and the enable register. A disabled line never raises it.
- R4: In edge mode (MODE=PIC_EDGE), a 0-to-1 change on irqIn[i] sets pending bit i. The bit is readable three clock edges after the input changes. A 1-to-0 change sets nothing.
- R5: In edge mode, a write with regSel=1 clears every pending bit where regWdata holds 1 and leaves the bits where it holds 0.
- R6: In level mode (MODE=PIC_LEVEL), pending bit i equals irqIn[i] delayed by two clock edges, and writes with regSel=1 have no effect.
- R7: In legacy mode (MODE=PIC_STICKY), a high irqIn[i] sets pending bit i three edges later. The bit stays set after the input falls, until software clears it.
- R8: In legacy mode, a write with regSel=1 clears every pending bit where regWdata holds 0 and leaves the bits where it holds 1.
- R9: When a clear to pending bit i falls in the same cycle as a new set event for that bit, the bit ends up set.
- R10: pendValid is 1 when any line is pending and enabled. pendIdx then gives the lowest such line number, counting bit 0 as line 0.
- R11: regRdata shows the enable register while regSel=0 and the pending register while regSel=1. It is combinational and reports all pending bits at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 32 | Interrupt request lines, asynchronous |
| regSel | input | 1 | Register select: 0 enable register, 1 pending register |
| regWe | input | 1 | Write strobe for the selected register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the selected register |
| cpuIrq | output | 1 | Interrupt request to the core |
| pendValid | output | 1 | Some enabled line is pending |
| pendIdx | output | 5 | Lowest enabled pending line |

## Verification
A pending bit held in a wrong state shows on regRdata with regSel=1 at the next read. With the line enabled, the same fault also reaches cpuIrq and pendIdx in the same cycle. A wrong acknowledge polarity or a clear that beats a set therefore shows up within one cycle of the offending write. Edge and legacy designs are told apart because the same stimulus drives all three modes side by side, so each mode's different answer is compared at the ports.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [1:0] {
    PIC_LEVEL  = 2'd0,
    PIC_EDGE   = 2'd1,
    PIC_STICKY = 2'd2
  } picMode_e;

  typedef struct packed {
    logic maskWr;
    logic statusWr;
  } picStrobe_t;

endpackage

// File: rtl/pic_lowest.sv
module pic_lowest #(
  parameter int NUM_LINES = 32,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] vec,
  output logic                 valid,
  output logic [IDX_W-1:0]     idx
);
  // Scan downward so the lowest set bit is the last one written.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (vec[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
  parameter int NUM_LINES = 32
) (
  input  logic                    regSel,
  input  logic                    regWe,
  input  logic [NUM_LINES-1:0]    maskQ,
  input  logic [NUM_LINES-1:0]    statusQ,
  output pic_pkg::picStrobe_t     strobe,
  output logic [NUM_LINES-1:0]    regRdata
);
  always_comb begin
    strobe.maskWr   = regWe & ~regSel;
    strobe.statusWr = regWe &  regSel;
  end

  assign regRdata = regSel ? statusQ : maskQ;
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath #(
  parameter int               NUM_LINES   = 32,
  parameter int               SYNC_STAGES = 2,
  parameter pic_pkg::picMode_e MODE       = pic_pkg::PIC_EDGE,
  localparam int              IDX_W       = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  pic_pkg::picStrobe_t  strobe,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] maskQ,
  output logic [NUM_LINES-1:0] statusQ,
  output logic                 cpuIrq,
  output logic                 pendValid,
  output logic [IDX_W-1:0]     pendIdx
);
  logic [SYNC_STAGES-1:0][NUM_LINES-1:0] syncPipe;
  logic [NUM_LINES-1:0] syncOut;
  logic [NUM_LINES-1:0] pending;

  always_ff @(posedge clk) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], irqIn};
  end
  assign syncOut = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN)              maskQ <= '0;
    else if (strobe.maskWr) maskQ <= wdata;
  end

  generate
    if (MODE == pic_pkg::PIC_LEVEL) begin : g_level
      logic levelUnused;
      assign levelUnused = strobe.statusWr;
      assign statusQ = syncOut;
    end else if (MODE == pic_pkg::PIC_EDGE) begin : g_edge
      logic [NUM_LINES-1:0] prevQ, rise, clrVec;
      assign rise   = syncOut & ~prevQ;
      assign clrVec = strobe.statusWr ? wdata : '0;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          prevQ   <= '0;
          statusQ <= '0;
        end else begin
          prevQ   <= syncOut;
          statusQ <= (statusQ & ~clrVec) | rise;
        end
      end
      // R5, R9: after a clear, only bits with a concurrent rise may remain set
      assert_w1c_R5: assert property (@(posedge clk) disable iff (!rstN)
        strobe.statusWr |=> ((statusQ & $past(wdata) & ~$past(rise)) == '0));
      // R4: without a write no pending bit ever falls
      assert_no_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.statusWr |=> (($past(statusQ) & ~statusQ) == '0));
    end else begin : g_sticky
      logic [NUM_LINES-1:0] keepVec;
      assign keepVec = strobe.statusWr ? wdata : '1;
      always_ff @(posedge clk) begin
        if (!rstN) statusQ <= '0;
        else       statusQ <= (statusQ & keepVec) | syncOut;
      end
      // R8, R9: zero-written bits clear unless the line is still asserted
      assert_w0c_R8: assert property (@(posedge clk) disable iff (!rstN)
        strobe.statusWr |=> ((statusQ & ~$past(wdata) & ~$past(syncOut)) == '0));
      assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.statusWr |=> (($past(statusQ) & ~statusQ) == '0));
    end
  endgenerate

  assign pending = statusQ & maskQ;
  assign cpuIrq  = |pending;

  pic_lowest #(.NUM_LINES(NUM_LINES)) u_lowest (
    .vec   (pending),
    .valid (pendValid),
    .idx   (pendIdx)
  );

  // R10: encoder output agrees with the wired-OR request
  assert_valid_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    pendValid == cpuIrq);
  // R10: the reported line is pending and no lower line is
  assert_lowest_R10: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> (pending[pendIdx] &&
      ((pending & ((NUM_LINES'(1) << pendIdx) - NUM_LINES'(1))) == '0)));
  // R2: an enable write lands in the register on the next cycle
  assert_mask_wr_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskWr |=> (maskQ == $past(wdata)));
endmodule

// File: rtl/spr_pic.sv
module spr_pic #(
  parameter int                NUM_LINES   = 32,
  parameter int                SYNC_STAGES = 2,
  parameter pic_pkg::picMode_e MODE        = pic_pkg::PIC_EDGE,
  localparam int               IDX_W       = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 regSel,
  input  logic                 regWe,
  input  logic [NUM_LINES-1:0] regWdata,
  output logic [NUM_LINES-1:0] regRdata,
  output logic                 cpuIrq,
  output logic                 pendValid,
  output logic [IDX_W-1:0]     pendIdx
);
  pic_pkg::picStrobe_t  strobe;
  logic [NUM_LINES-1:0] maskQ, statusQ;

  pic_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .regSel   (regSel),
    .regWe    (regWe),
    .maskQ    (maskQ),
    .statusQ  (statusQ),
    .strobe   (strobe),
    .regRdata (regRdata)
  );

  pic_datapath #(
    .NUM_LINES   (NUM_LINES),
    .SYNC_STAGES (SYNC_STAGES),
    .MODE        (MODE)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .strobe    (strobe),
    .wdata     (regWdata),
    .maskQ     (maskQ),
    .statusQ   (statusQ),
    .cpuIrq    (cpuIrq),
    .pendValid (pendValid),
    .pendIdx   (pendIdx)
  );
endmodule

// File: tb/spr_pic_bench.sv
module spr_pic_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic        regSel = 1'b0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdE, rdS, rdL;
  logic        irqE, irqS, irqL, vE, vS, vL;
  logic [4:0]  idxE, idxS, idxL;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spr_pic #(.MODE(pic_pkg::PIC_EDGE)) u_spr_pic (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regSel(regSel), .regWe(regWe),
    .regWdata(regWdata), .regRdata(rdE), .cpuIrq(irqE), .pendValid(vE), .pendIdx(idxE));
  spr_pic #(.MODE(pic_pkg::PIC_STICKY)) u_spr_pic_sticky (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regSel(regSel), .regWe(regWe),
    .regWdata(regWdata), .regRdata(rdS), .cpuIrq(irqS), .pendValid(vS), .pendIdx(idxS));
  spr_pic #(.MODE(pic_pkg::PIC_LEVEL)) u_spr_pic_level (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regSel(regSel), .regWe(regWe),
    .regWdata(regWdata), .regRdata(rdL), .cpuIrq(irqL), .pendValid(vL), .pendIdx(idxL));

  typedef struct packed {
    logic [31:0] irq;
    logic [1:0]  op;    // 0 none, 1 enable write, 2 pending write
    logic [31:0] wd;
    logic [31:0] expE;
    logic [31:0] expS;
    logic [31:0] expL;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0005, 2'd1, 32'hFFFF_FFFF, 32'h0000_0005, 32'h0000_0005, 32'h0000_0005},
    '{32'h0000_0000, 2'd0, 32'h0000_0000, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000},
    '{32'h0000_0000, 2'd2, 32'h0000_0001, 32'h0000_0004, 32'h0000_0001, 32'h0000_0000},
    '{32'h0000_0000, 2'd2, 32'hFFFF_FFFE, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    '{32'h8000_0000, 2'd0, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000},
    '{32'h8000_0000, 2'd2, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000},
    '{32'h8000_0000, 2'd2, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000},
    '{32'h0000_0000, 2'd2, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    '{32'h0001_0000, 2'd1, 32'h0000_0000, 32'h0001_0000, 32'h0001_0000, 32'h0001_0000},
    '{32'h0001_0000, 2'd1, 32'h0001_0000, 32'h0001_0000, 32'h0001_0000, 32'h0001_0000},
    '{32'h0001_0002, 2'd0, 32'h0000_0000, 32'h0001_0002, 32'h0001_0002, 32'h0001_0002},
    '{32'h0001_0002, 2'd1, 32'hFFFF_FFFF, 32'h0001_0002, 32'h0001_0002, 32'h0001_0002}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [5:0] lowest(input logic [31:0] v);
    logic [5:0] r = 6'd32;
    for (int i = 31; i >= 0; i--) if (v[i]) r = 6'(i);
    return r;
  endfunction

  // cpuIrq, pendValid and pendIdx of one instance against the expected pending set
  task automatic checkOut(input string name, input logic [31:0] pend, input logic [31:0] msk,
                          input logic irq, input logic v, input logic [4:0] idx);
    logic [31:0] act = pend & msk;
    logic [5:0]  lo  = lowest(act);
    check({name, " R3 cpuIrq"}, {31'd0, irq}, {31'd0, |act});
    check({name, " R10 pendValid"}, {31'd0, v}, {31'd0, |act});
    if (|act) check({name, " R10 pendIdx"}, {27'd0, idx}, {27'd0, lo[4:0]});
  endtask

  logic [31:0] expMask = '0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regSel = 1'b0; #1;
    check("R1 enable reset", rdE, 32'h0);
    regSel = 1'b1; #1;
    check("R1 pending reset edge", rdE, 32'h0);
    check("R1 pending reset sticky", rdS, 32'h0);
    check("R1 pending reset level", rdL, 32'h0);
    check("R1 outputs low", {28'd0, irqE, vE, irqS, vS}, 32'h0);

    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      irqIn = VECS[n].irq;
      repeat (4) @(negedge clk);
      if (VECS[n].op != 2'd0) begin
        regSel   = (VECS[n].op == 2'd2);
        regWdata = VECS[n].wd;
        regWe    = 1'b1;
        @(negedge clk);
        regWe = 1'b0;
        if (VECS[n].op == 2'd1) expMask = VECS[n].wd;
      end
      regSel = 1'b1; #1;
      check($sformatf("R4/R5 edge pending step %0d", n), rdE, VECS[n].expE);
      check($sformatf("R7/R8 sticky pending step %0d", n), rdS, VECS[n].expS);
      check($sformatf("R6 level pending step %0d", n), rdL, VECS[n].expL);
      regSel = 1'b0; #1;
      check($sformatf("R2/R11 enable readback step %0d", n), rdE, expMask);
      checkOut("edge", VECS[n].expE, expMask, irqE, vE, idxE);
      checkOut("sticky", VECS[n].expS, expMask, irqS, vS, idxS);
      checkOut("level", VECS[n].expL, expMask, irqL, vL, idxL);
    end

    // R9: a one-to-clear lands in the cycle the new rise on line 3 is latched
    @(negedge clk);
    irqIn = 32'h0001_000A;
    @(negedge clk);
    @(negedge clk);
    regSel = 1'b1; regWdata = 32'h0000_0008; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; #1;
    check("R9 set beats clear edge", rdE, 32'h0001_000A);

    // R7: sticky keeps line 3 after the input drops; level drops it
    @(negedge clk);
    irqIn = 32'h0001_0002;
    repeat (4) @(negedge clk);
    #1;
    check("R7 sticky holds after fall", rdS, 32'h0001_000A);
    check("R6 level follows fall", rdL, 32'h0001_0002);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule